// File: doc/BRIEF.md
# Gated Special-Register Access Unit

This unit sits beside the execute stage of a 64-bit processor core and owns one 25-bit stream-control register, which tunes data prefetching but drives no other logic here. The same physical register answers at two special-register numbers: a user-visible alias and a privileged alias. Two facility-control registers each carry an enable bit for it, and software can read and write both.

On every move-to or move-from request the unit decodes the register number and compares the privilege mode with the two enable bits. It then does one of three things. It completes the access. It flags a privileged-register violation. Or it raises a facility-unavailable exception, which carries a vector, a hypervisor flag and a cause code written into the matching facility-control register.

The exception and violation outputs are combinational and share the request cycle. Read data is registered and arrives one cycle after the request.

Top module: `gated_sreg_unit`

## Requirements
- R1: After reset:
  - the stream-control register reads as zero;
  - both facility-control registers read with their enable bit (bit 2) set and their cause field (bits 59..56) zero;
  - `rd_valid` is 0.
- R2: A completed write to the stream-control register captures bits 24..0 of `req_wdata`. A completed read returns those 25 bits in bits 24..0 of `rd_data`, with bits 63..25 zero.
- R3: Register numbers 3 and 17 reach the same storage: a value written through one alias is read back through the other.
- R4: A user-mode access through number 3 while the hypervisor enable bit is 0 has these effects, and changes neither the data register nor `rd_valid`:
  - `exc_valid` = 1, `exc_hv` = 1 and `exc_vector` = 0xF80;
  - cause code 2 is written into bits 59..56 of the hypervisor facility-control register.
- R5: A user-mode access through number 3 while the hypervisor enable bit is 1 and the ordinary enable bit is 0 has these effects, and changes neither the data register nor `rd_valid`:
  - `exc_valid` = 1, `exc_hv` = 0 and `exc_vector` = 0xF60;
  - cause code 2 is written into bits 59..56 of the ordinary facility-control register.
- R6: A user-mode access through number 17 sets `illegal` = 1 and `exc_valid` = 0 for any values of the enable bits. It has no effect on any storage and produces no read data.
- R7: A privileged-mode access (`req_user` = 0) through number 3 or 17 always completes, for any values of the enable bits.
- R8: The facility-control registers sit at parameter numbers `FAC_NUM` (default 153) and `HFAC_NUM` (default 190). Only the enable bit (bit 2) and the cause field (bits 59..56) are stored, and every other bit reads 0. A privileged write sets both fields from the write data. A user-mode access to either register sets `illegal` = 1 and has no effect.
- R9: `exc_valid` and `illegal` are 1 only in a cycle where `req_valid` is 1, and never both at once.
- R10: `rd_valid` is 1 exactly one cycle after a completed read. A request to any other register number produces no read data, no exception and no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Single-cycle request strobe |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_num | input | 10 | Special-register number |
| req_wdata | input | 64 | Write data |
| req_user | input | 1 | 1 = user (problem-state) mode, 0 = privileged |
| rd_valid | output | 1 | Read data valid, one cycle after a completed read |
| rd_data | output | 64 | Registered read data |
| exc_valid | output | 1 | Facility-unavailable exception, same cycle as the request |
| exc_hv | output | 1 | Exception is hypervisor-level |
| exc_vector | output | 12 | Exception vector (0xF60 or 0xF80) |
| illegal | output | 1 | Privileged-register violation, same cycle as the request |

## Verification
The bench builds the unit with its default parameters: a 25-bit data register, a 10-bit register number, facility registers at 153 and 190, and cause code 2. With those values the whole decision space is small enough to sweep completely. Every combination of the two enable bits is crossed with both modes, both directions and five register numbers (both aliases, both facility registers and one unmapped number). This reaches every exception vector, every cause-field update and every violation case against a bench-side model. Writes of all ones to the data register show that the upper 39 bits stay zero on read-back.

// File: rtl/gsu_pkg.sv
package gsu_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_DATA = 2'd1,
    TGT_FAC  = 2'd2,
    TGT_HFAC = 2'd3
  } tgt_e;

  typedef struct packed {
    tgt_e tgt;
    logic priv_only;
    logic gated;
  } dec_t;
endpackage

// File: rtl/gsu_rst_sync.sv
module gsu_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/gsu_decode.sv
module gsu_decode
  import gsu_pkg::*;
#(
  parameter int NUM_W    = 10,
  parameter int UALIAS   = 3,
  parameter int PALIAS   = 17,
  parameter int FAC_NUM  = 153,
  parameter int HFAC_NUM = 190
) (
  input  logic [NUM_W-1:0] num,
  output dec_t             dec
);
  always_comb begin
    dec.tgt       = TGT_NONE;
    dec.priv_only = 1'b0;
    dec.gated     = 1'b0;
    if (num == NUM_W'(UALIAS)) begin
      dec.tgt   = TGT_DATA;
      dec.gated = 1'b1;
    end else if (num == NUM_W'(PALIAS)) begin
      dec.tgt       = TGT_DATA;
      dec.priv_only = 1'b1;
    end else if (num == NUM_W'(FAC_NUM)) begin
      dec.tgt       = TGT_FAC;
      dec.priv_only = 1'b1;
    end else if (num == NUM_W'(HFAC_NUM)) begin
      dec.tgt       = TGT_HFAC;
      dec.priv_only = 1'b1;
    end
  end
endmodule

// File: rtl/gsu_gate.sv
module gsu_gate
  import gsu_pkg::*;
#(
  parameter int          VEC_W  = 12,
  parameter logic [11:0] VEC_OS = 12'hF60,
  parameter logic [11:0] VEC_HV = 12'hF80
) (
  input  logic             req_valid,
  input  logic             req_user,
  input  dec_t             dec,
  input  logic             fac_en,
  input  logic             hfac_en,
  output logic             complete,
  output logic             exc_valid,
  output logic             exc_hv,
  output logic [VEC_W-1:0] exc_vector,
  output logic             illegal,
  output logic [1:0]       set_cause
);
  logic blocked;

  always_comb begin
    illegal    = req_valid && req_user && dec.priv_only;
    blocked    = req_valid && req_user && dec.gated && !(fac_en && hfac_en);
    exc_valid  = blocked;
    exc_hv     = blocked && !hfac_en;
    exc_vector = '0;
    if (blocked) exc_vector = hfac_en ? VEC_W'(VEC_OS) : VEC_W'(VEC_HV);
    complete     = req_valid && (dec.tgt != TGT_NONE) && !illegal && !blocked;
    set_cause[0] = blocked && hfac_en;
    set_cause[1] = blocked && !hfac_en;
  end
endmodule

// File: rtl/gsu_regs.sv
module gsu_regs
  import gsu_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int DATA_W     = 25,
  parameter int ENA_BIT    = 2,
  parameter int CAUSE_LSB  = 56,
  parameter int CAUSE_W    = 4,
  parameter int CAUSE_CODE = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            complete,
  input  logic            write,
  input  tgt_e            tgt,
  input  logic [XLEN-1:0] wdata,
  input  logic [1:0]      set_cause,
  output logic [1:0]      en_o,
  output logic            rd_valid,
  output logic [XLEN-1:0] rd_data
);
  localparam int NFAC = 2;

  logic [DATA_W-1:0]             data_q, data_d;
  logic [NFAC-1:0][CAUSE_W-1:0]  cause_all;
  logic [XLEN-1:0]               rd_d;
  logic                          rd_valid_d, rd_en;

  // stream-control data register
  always_comb begin
    data_d = data_q;
    if (complete && write && tgt == TGT_DATA) data_d = wdata[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  // facility-control registers: index 0 ordinary, 1 hypervisor
  for (genvar g = 0; g < NFAC; g++) begin : g_fac
    localparam tgt_e MY_TGT = (g == 0) ? TGT_FAC : TGT_HFAC;
    logic               en_q, en_d;
    logic [CAUSE_W-1:0] cause_q, cause_d;

    always_comb begin
      en_d    = en_q;
      cause_d = cause_q;
      if (complete && write && tgt == MY_TGT) begin
        en_d    = wdata[ENA_BIT];
        cause_d = wdata[CAUSE_LSB +: CAUSE_W];
      end else if (set_cause[g]) begin
        cause_d = CAUSE_W'(CAUSE_CODE);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q    <= 1'b1;
        cause_q <= '0;
      end else begin
        en_q    <= en_d;
        cause_q <= cause_d;
      end
    end

    assign en_o[g]      = en_q;
    assign cause_all[g] = cause_q;
  end

  // read path, registered with a clock enable
  always_comb begin
    rd_valid_d = complete && !write;
    rd_en      = rd_valid_d;
    rd_d       = '0;
    case (tgt)
      TGT_DATA: rd_d = XLEN'(data_q);
      TGT_FAC: begin
        rd_d[ENA_BIT]                 = en_o[0];
        rd_d[CAUSE_LSB +: CAUSE_W]    = cause_all[0];
      end
      TGT_HFAC: begin
        rd_d[ENA_BIT]                 = en_o[1];
        rd_d[CAUSE_LSB +: CAUSE_W]    = cause_all[1];
      end
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_valid <= 1'b0;
    else            rd_valid <= rd_valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_d;
  end

  // R4 / R5: a blocked access leaves the data register untouched
  a_r4_blocked_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_cause) |=> $stable(data_q));

  // R10: read data appears only one cycle after a completed read
  a_r10_rd_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(complete && !write));

  // R2: upper bits of a data-register read are zero
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(tgt == TGT_DATA)) |-> (rd_data[XLEN-1:DATA_W] == '0));
endmodule

// File: rtl/gated_sreg_unit.sv
module gated_sreg_unit
  import gsu_pkg::*;
#(
  parameter int          XLEN       = 64,
  parameter int          DATA_W     = 25,
  parameter int          NUM_W      = 10,
  parameter int          UALIAS     = 3,
  parameter int          PALIAS     = 17,
  parameter int          FAC_NUM    = 153,
  parameter int          HFAC_NUM   = 190,
  parameter int          ENA_BIT    = 2,
  parameter int          CAUSE_LSB  = 56,
  parameter int          CAUSE_W    = 4,
  parameter int          CAUSE_CODE = 2,
  parameter int          VEC_W      = 12,
  parameter logic [11:0] VEC_OS     = 12'hF60,
  parameter logic [11:0] VEC_HV     = 12'hF80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [NUM_W-1:0] req_num,
  input  logic [XLEN-1:0]  req_wdata,
  input  logic             req_user,
  output logic             rd_valid,
  output logic [XLEN-1:0]  rd_data,
  output logic             exc_valid,
  output logic             exc_hv,
  output logic [VEC_W-1:0] exc_vector,
  output logic             illegal
);
  logic       rst_int_n;
  dec_t       dec;
  logic       complete;
  logic [1:0] set_cause;
  logic [1:0] en;

  gsu_rst_sync u_rst (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_int_n));

  gsu_decode #(
    .NUM_W(NUM_W), .UALIAS(UALIAS), .PALIAS(PALIAS),
    .FAC_NUM(FAC_NUM), .HFAC_NUM(HFAC_NUM)
  ) u_dec (.num(req_num), .dec(dec));

  gsu_gate #(.VEC_W(VEC_W), .VEC_OS(VEC_OS), .VEC_HV(VEC_HV)) u_gate (
    .req_valid (req_valid),
    .req_user  (req_user),
    .dec       (dec),
    .fac_en    (en[0]),
    .hfac_en   (en[1]),
    .complete  (complete),
    .exc_valid (exc_valid),
    .exc_hv    (exc_hv),
    .exc_vector(exc_vector),
    .illegal   (illegal),
    .set_cause (set_cause)
  );

  gsu_regs #(
    .XLEN(XLEN), .DATA_W(DATA_W), .ENA_BIT(ENA_BIT),
    .CAUSE_LSB(CAUSE_LSB), .CAUSE_W(CAUSE_W), .CAUSE_CODE(CAUSE_CODE)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .complete (complete),
    .write    (req_write),
    .tgt      (dec.tgt),
    .wdata    (req_wdata),
    .set_cause(set_cause),
    .en_o     (en),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  // R9: exception and violation only with a request, never together
  a_r9_exc_needs_req: assert property (@(posedge clk) disable iff (!rst_int_n)
    (exc_valid || illegal) |-> req_valid);
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(exc_valid && illegal));

  // R7: privileged access to either alias never faults
  a_r7_priv_completes: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && !req_user && dec.tgt == TGT_DATA) |-> (!exc_valid && !illegal));

  // R4 / R5: vector matches the exception level
  a_r5_vector_level: assert property (@(posedge clk) disable iff (!rst_int_n)
    exc_valid |-> (exc_vector == (exc_hv ? VEC_W'(VEC_HV) : VEC_W'(VEC_OS))));

  // R6: user access through the privileged alias is a violation
  a_r6_palias_illegal: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && req_user && req_num == NUM_W'(PALIAS)) |-> (illegal && !exc_valid));
endmodule

// File: tb/gated_sreg_unit_test.sv
`timescale 1ns/1ps
module gated_sreg_unit_test;
  localparam int FACN  = 153;
  localparam int HFACN = 190;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_user;
  logic [9:0]  req_num;
  logic [63:0] req_wdata;
  logic        rd_valid, exc_valid, exc_hv, illegal;
  logic [63:0] rd_data;
  logic [11:0] exc_vector;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [24:0] m_data;
  logic        m_fen, m_hen;
  logic [3:0]  m_fcause, m_hcause;

  always #4 clk = ~clk;

  gated_sreg_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_num(req_num), .req_wdata(req_wdata), .req_user(req_user),
    .rd_valid(rd_valid), .rd_data(rd_data), .exc_valid(exc_valid),
    .exc_hv(exc_hv), .exc_vector(exc_vector), .illegal(illegal)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] fac_val(input logic en, input logic [3:0] c);
    logic [63:0] v;
    v = '0;
    v[2] = en;
    v[59:56] = c;
    return v;
  endfunction

  task automatic do_req(input logic wr, input logic [9:0] num,
                        input logic [63:0] wd, input logic usr);
    logic        e_ill, e_exc, e_hv, e_rdv;
    logic [11:0] e_vec;
    logic [63:0] e_rd;
    string       tag;
    e_ill = 0; e_exc = 0; e_hv = 0; e_rdv = 0; e_vec = '0; e_rd = '0;
    tag = "R10";
    if (usr && (num == 10'd17 || num == 10'(FACN) || num == 10'(HFACN))) begin
      e_ill = 1;
      tag = (num == 10'd17) ? "R6" : "R8";
    end else if (usr && num == 10'd3 && !(m_fen && m_hen)) begin
      e_exc = 1;
      e_hv  = !m_hen;
      e_vec = m_hen ? 12'hF60 : 12'hF80;
      tag   = m_hen ? "R5" : "R4";
    end else if (num == 10'd3 || num == 10'd17) begin
      tag = usr ? "R2" : "R7";
      if (wr) m_data = wd[24:0];
      else begin e_rdv = 1; e_rd = {39'b0, m_data}; end
    end else if (num == 10'(FACN) || num == 10'(HFACN)) begin
      tag = "R8";
      if (wr) begin
        if (num == 10'(FACN)) begin m_fen = wd[2]; m_fcause = wd[59:56]; end
        else                  begin m_hen = wd[2]; m_hcause = wd[59:56]; end
      end else begin
        e_rdv = 1;
        e_rd  = (num == 10'(FACN)) ? fac_val(m_fen, m_fcause) : fac_val(m_hen, m_hcause);
      end
    end
    @(negedge clk);
    req_valid = 1; req_write = wr; req_num = num; req_wdata = wd; req_user = usr;
    #1;
    chk(tag, "illegal", 64'(illegal), 64'(e_ill));
    chk(tag, "exc_valid", 64'(exc_valid), 64'(e_exc));
    chk(tag, "exc_hv", 64'(exc_hv), 64'(e_hv));
    if (e_exc) chk(tag, "exc_vector", 64'(exc_vector), 64'(e_vec));
    // cause-field update takes effect at the edge
    if (e_exc && e_hv)  m_hcause = 4'd2;
    if (e_exc && !e_hv) m_fcause = 4'd2;
    @(negedge clk);
    req_valid = 0;
    chk(tag, "rd_valid", 64'(rd_valid), 64'(e_rdv));
    if (e_rdv) chk(tag, "rd_data", rd_data, e_rd);
    #1;
    chk("R9", "idle exc_valid", 64'(exc_valid), 64'd0);
    chk("R9", "idle illegal", 64'(illegal), 64'd0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [9:0] nums [5];
    logic [63:0] wd;
    int k;
    nums[0] = 10'd3; nums[1] = 10'd17; nums[2] = 10'(FACN);
    nums[3] = 10'(HFACN); nums[4] = 10'd5;
    req_valid = 0; req_write = 0; req_num = '0; req_wdata = '0; req_user = 0;
    rst_n = 0;
    m_data = '0; m_fen = 1; m_hen = 1; m_fcause = '0; m_hcause = '0;
    repeat (3) @(negedge clk);
    chk("R1", "rd_valid in reset", 64'(rd_valid), 64'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: reset contents
    do_req(0, 10'd17, '0, 0);
    do_req(0, 10'(FACN), '0, 0);
    do_req(0, 10'(HFACN), '0, 0);
    // R2: all-ones write keeps upper bits zero
    do_req(1, 10'd3, '1, 0);
    do_req(0, 10'd3, '0, 0);
    // R3: write via one alias, read via the other
    do_req(1, 10'd3, 64'h0000_0000_0155_AA33, 1);
    do_req(0, 10'd17, '0, 0);
    do_req(1, 10'd17, 64'hFFFF_0000_00AB_CDEF, 0);
    do_req(0, 10'd3, '0, 1);
    // full sweep over enables, mode, number and direction
    k = 0;
    for (int combo = 0; combo < 4; combo++) begin
      do_req(1, 10'(FACN),  fac_val(combo[0], 4'(combo)), 0);
      do_req(1, 10'(HFACN), fac_val(combo[1], 4'(combo + 8)), 0);
      for (int usr = 0; usr < 2; usr++)
        for (int ni = 0; ni < 5; ni++)
          for (int wr = 0; wr < 2; wr++) begin
            k++;
            wd = {32'(k * 32'h9E37_79B9), 32'(k * 32'h85EB_CA6B)};
            if (nums[ni] == 10'(FACN))  wd[2] = m_fen;
            if (nums[ni] == 10'(HFACN)) wd[2] = m_hen;
            do_req(1'(wr), nums[ni], wd, 1'(usr));
            // observe data register after every request
            do_req(0, 10'd17, '0, 0);
          end
      // cause fields after this combination
      do_req(0, 10'(FACN), '0, 0);
      do_req(0, 10'(HFACN), '0, 0);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule